// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block holds the tags, valid bits and data words of a small two-way set-associative cache and runs the lookup for one request at a time. Each set keeps a one-bit prediction that names the way expected to hit next. On an access, only that way's tag is compared, and the read-data multiplexer is already steered to that way. A correct guess therefore answers in the first cycle after the request is accepted.

When the guess is wrong, the other way is compared in the next cycle. A match there gives a slow hit in the third cycle, and the set's prediction is retrained. When neither way matches, the block asks a memory model for the line over a refill port. It installs the line, points the prediction at it and reports a miss. Writes allocate on a miss and overwrite the word on a hit. Each line is a single data word.

Top module: `wpred_cache`

## Requirements
- R1: After reset every line is invalid, every set predicts way 0, `req_ready_o` is 1 and `resp_valid_o` is 0.
- R2: If the predicted way holds the requested tag, the response comes in the first cycle after acceptance. It has `resp_hit_o`=1, and on a read it carries that way's word.
- R3: If only the non-predicted way holds the tag, the response comes in the third cycle after acceptance. It has `resp_slow_o`=1, and on a read it carries that way's word.
- R4: After a slow hit, the set's prediction names the way that hit, so an immediate repeat of the access is a fast hit.
- R5: If neither way holds the tag, `refill_req_o` is raised with `refill_addr_o` equal to the request address. After the cycle in which `refill_valid_i` is sampled high, the next cycle responds with `resp_miss_o`=1, and a read returns the refill word.
- R6: The refilled line goes to way 0 if way 0 is invalid. Otherwise it goes to way 1 if way 1 is invalid. Otherwise it goes to the non-predicted way. The prediction is then set to the refilled way.
- R7: An invalid line never matches, whatever its stored tag.
- R8: From acceptance until the response cycle ends, `req_ready_o` is 0, so only one request is in flight.
- R9: A write hit stores the write word in the matching way, with the same 1-cycle or 3-cycle timing as a read. A write miss installs the write word in place of the refill word.
- R10: In every cycle with `resp_valid_o`=1, exactly one of hit, slow and miss is 1. In every other cycle all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_addr_i | input | ADDR_W | Word address; the low IDX_W bits pick the set, the rest is the tag |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write word |
| resp_valid_o | output | 1 | Response this cycle |
| resp_rdata_o | output | DATA_W | Read word (meaningful for reads) |
| resp_hit_o | output | 1 | Fast hit in the predicted way |
| resp_slow_o | output | 1 | Hit in the non-predicted way |
| resp_miss_o | output | 1 | Line was refilled |
| refill_req_o | output | 1 | Line wanted from memory |
| refill_addr_o | output | ADDR_W | Address of the wanted line |
| refill_valid_i | input | 1 | Refill word present |
| refill_data_i | input | DATA_W | Refill word |

## Verification
The bench keeps its own model of the tags, valid bits and predictions of every set, and predicts the kind, latency and data of each access. It first runs a directed sequence in one set and then a long pseudo-random mix of reads and writes with three tags contending per set.

The directed sequence covers several ways to get the design wrong:
- A first access to address zero after reset exposes a design that lets an invalid line match its reset tag; it would answer fast instead of missing.
- A repeat after a slow hit exposes a predictor that is never retrained; that repeat would be slow again.
- A third tag in a full set exposes a wrong victim choice. The wrong line would be evicted, and a later access to the surviving tag would miss.
- Reads after writes expose dropped write data, which would return the old or the refill word.

// File: rtl/wpred_cache_pkg.sv
// Shared types for the way-predicted cache lookup.
// Assumes exactly two ways, so a way is named by one bit.
package wpred_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // ready for a request
        ST_PRED,   // compare the predicted way
        ST_ALT,    // compare the other way
        ST_SLOW,   // answer a slow hit
        ST_FILL,   // wait for the refill word
        ST_MISS    // answer a refilled miss
    } lookup_state_e;

endpackage

// File: rtl/wpred_cache_store.sv
// Line storage: valid bit, tag and data word per way and set, and one
// prediction bit per set. Reads are combinational at rd_idx_i; one line
// write and one prediction write per cycle. Assumes two ways.
module wpred_cache_store #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            rd_idx_i,
    output logic [1:0]                  rd_valid_o,
    output logic [1:0][TAG_W-1:0]       rd_tag_o,
    output logic [1:0][DATA_W-1:0]      rd_data_o,
    output logic                        rd_pred_o,
    input  logic                        wr_en_i,
    input  logic                        wr_way_i,
    input  logic [TAG_W-1:0]            wr_tag_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic                        pred_we_i,
    input  logic                        pred_val_i
);
    logic pred_q [SETS];

    // Prediction bits: cleared to way 0 on reset, rewritten on retrain or fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) pred_q[s] <= 1'b0;
        end else if (pred_we_i) begin
            pred_q[rd_idx_i] <= pred_val_i;
        end
    end

    assign rd_pred_o = pred_q[rd_idx_i];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic              valid_q [SETS];
        logic [TAG_W-1:0]  tag_q   [SETS];
        logic [DATA_W-1:0] data_q  [SETS];

        // Valid bits: all cleared on reset, set when this way is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= 1'b0;
            end else if (wr_en_i && wr_way_i == 1'(w)) begin
                valid_q[rd_idx_i] <= 1'b1;
            end
        end

        // Tag and data words: no reset, written with the line.
        always_ff @(posedge clk) begin
            if (wr_en_i && wr_way_i == 1'(w)) begin
                tag_q[rd_idx_i]  <= wr_tag_i;
                data_q[rd_idx_i] <= wr_data_i;
            end
        end

        assign rd_valid_o[w] = valid_q[rd_idx_i];
        assign rd_tag_o[w]   = tag_q[rd_idx_i];
        assign rd_data_o[w]  = data_q[rd_idx_i];
    end

endmodule

// File: rtl/wpred_cache_ctrl.sv
// Lookup sequencer: latches one request, compares the predicted way,
// then the other way, then refills; drives the storage write ports and
// the response. Assumes two ways and one word per line.
module wpred_cache_ctrl
    import wpred_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SETS   = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic                   req_we_i,
    input  logic [DATA_W-1:0]      req_wdata_i,
    output logic                   resp_valid_o,
    output logic [DATA_W-1:0]      resp_rdata_o,
    output logic                   resp_hit_o,
    output logic                   resp_slow_o,
    output logic                   resp_miss_o,
    output logic                   refill_req_o,
    output logic [ADDR_W-1:0]      refill_addr_o,
    input  logic                   refill_valid_i,
    input  logic [DATA_W-1:0]      refill_data_i,
    output logic [IDX_W-1:0]       idx_o,
    input  logic [1:0]             rd_valid_i,
    input  logic [1:0][TAG_W-1:0]  rd_tag_i,
    input  logic [1:0][DATA_W-1:0] rd_data_i,
    input  logic                   rd_pred_i,
    output logic                   wr_en_o,
    output logic                   wr_way_o,
    output logic [TAG_W-1:0]       wr_tag_o,
    output logic [DATA_W-1:0]      wr_data_o,
    output logic                   pred_we_o,
    output logic                   pred_val_o
);
    lookup_state_e     state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              way_q, way_d;
    logic [TAG_W-1:0]  cur_tag;
    logic [1:0]        match;
    logic              pw, aw, victim, sel;

    assign cur_tag = addr_q[ADDR_W-1:IDX_W];
    assign idx_o   = addr_q[IDX_W-1:0];
    assign pw      = rd_pred_i;
    assign aw      = ~rd_pred_i;

    // Per-way tag compare; an invalid line never matches.
    always_comb begin
        for (int w = 0; w < 2; w++) match[w] = rd_valid_i[w] && (rd_tag_i[w] == cur_tag);
    end

    // Victim: first invalid way, else the way not predicted.
    always_comb begin
        if (!rd_valid_i[0])      victim = 1'b0;
        else if (!rd_valid_i[1]) victim = 1'b1;
        else                     victim = aw;
    end

    // Next state, response flags and storage writes for the current step.
    always_comb begin
        state_d      = state_q;
        way_d        = way_q;
        req_ready_o  = 1'b0;
        resp_hit_o   = 1'b0;
        resp_slow_o  = 1'b0;
        resp_miss_o  = 1'b0;
        refill_req_o = 1'b0;
        wr_en_o      = 1'b0;
        wr_way_o     = way_q;
        pred_we_o    = 1'b0;
        pred_val_o   = way_q;
        sel          = way_q;
        case (state_q)
            ST_IDLE: begin
                req_ready_o = 1'b1;
                if (req_valid_i) state_d = ST_PRED;
            end
            ST_PRED: begin
                sel = pw;
                if (match[pw]) begin
                    resp_hit_o = 1'b1;
                    wr_en_o    = we_q;
                    wr_way_o   = pw;
                    state_d    = ST_IDLE;
                end else begin
                    state_d = ST_ALT;
                end
            end
            ST_ALT: begin
                if (match[aw]) begin
                    wr_en_o    = we_q;
                    wr_way_o   = aw;
                    pred_we_o  = 1'b1;
                    pred_val_o = aw;
                    way_d      = aw;
                    state_d    = ST_SLOW;
                end else begin
                    way_d   = victim;
                    state_d = ST_FILL;
                end
            end
            ST_SLOW: begin
                resp_slow_o = 1'b1;
                state_d     = ST_IDLE;
            end
            ST_FILL: begin
                refill_req_o = 1'b1;
                if (refill_valid_i) begin
                    wr_en_o   = 1'b1;
                    pred_we_o = 1'b1;
                    state_d   = ST_MISS;
                end
            end
            ST_MISS: begin
                resp_miss_o = 1'b1;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign resp_valid_o  = resp_hit_o | resp_slow_o | resp_miss_o;
    assign resp_rdata_o  = rd_data_i[sel];
    assign refill_addr_o = addr_q;
    assign wr_tag_o      = cur_tag;
    assign wr_data_o     = (state_q == ST_FILL && !we_q) ? refill_data_i : wdata_q;

    // Sequencer state and way register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            way_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            way_q   <= way_d;
        end
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (req_valid_i && req_ready_o) begin
            addr_q  <= req_addr_i;
            we_q    <= req_we_i;
            wdata_q <= req_wdata_i;
        end
    end

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R10
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> $countones({resp_hit_o, resp_slow_o, resp_miss_o}) == 1);

    // R2
    fast_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit_o |-> $past(req_valid_i && req_ready_o));

    // R3
    slow_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_slow_o |-> ($past(state_q, 2) == ST_PRED && !$past(resp_valid_o)));

    // R4
    retrain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_slow_o |-> rd_pred_i == way_q);

    // R6
    fill_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_miss_o |-> (rd_valid_i[way_q] && rd_tag_i[way_q] == cur_tag && rd_pred_i == way_q));

endmodule

// File: rtl/wpred_cache.sv
// Top of the way-predicted two-way cache lookup: sequencer plus line
// storage. One request in flight; one data word per line.
module wpred_cache #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SETS   = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_we_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              resp_valid_o,
    output logic [DATA_W-1:0] resp_rdata_o,
    output logic              resp_hit_o,
    output logic              resp_slow_o,
    output logic              resp_miss_o,
    output logic              refill_req_o,
    output logic [ADDR_W-1:0] refill_addr_o,
    input  logic              refill_valid_i,
    input  logic [DATA_W-1:0] refill_data_i
);
    logic [IDX_W-1:0]        idx;
    logic [1:0]              rd_valid;
    logic [1:0][TAG_W-1:0]   rd_tag;
    logic [1:0][DATA_W-1:0]  rd_data;
    logic                    rd_pred;
    logic                    wr_en, wr_way, pred_we, pred_val;
    logic [TAG_W-1:0]        wr_tag;
    logic [DATA_W-1:0]       wr_data;

    wpred_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
        .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
        .resp_valid_o(resp_valid_o), .resp_rdata_o(resp_rdata_o), .resp_hit_o(resp_hit_o),
        .resp_slow_o(resp_slow_o), .resp_miss_o(resp_miss_o),
        .refill_req_o(refill_req_o), .refill_addr_o(refill_addr_o),
        .refill_valid_i(refill_valid_i), .refill_data_i(refill_data_i),
        .idx_o(idx), .rd_valid_i(rd_valid), .rd_tag_i(rd_tag), .rd_data_i(rd_data),
        .rd_pred_i(rd_pred), .wr_en_o(wr_en), .wr_way_o(wr_way), .wr_tag_o(wr_tag),
        .wr_data_o(wr_data), .pred_we_o(pred_we), .pred_val_o(pred_val)
    );

    wpred_cache_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n), .rd_idx_i(idx),
        .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_data_o(rd_data), .rd_pred_o(rd_pred),
        .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_tag_i(wr_tag), .wr_data_i(wr_data),
        .pred_we_i(pred_we), .pred_val_i(pred_val)
    );

endmodule

// File: tb/wpred_cache_tb.sv
// Bench: reference model of tags, valid bits and predictions per set;
// directed sequence in set 0, then a pseudo-random read/write mix.
module wpred_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int SETS   = 4;
    localparam int IDX_W  = 2;
    localparam int TAG_W  = ADDR_W - IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, resp_valid, resp_hit, resp_slow, resp_miss, refill_req;
    logic [DATA_W-1:0] resp_rdata;
    logic [ADDR_W-1:0] refill_addr;
    logic refill_valid;
    logic [DATA_W-1:0] refill_data;
    logic [1:0] mem_cnt;

    int n_chk = 0;
    int n_bad = 0;

    logic              mv [SETS][2];
    logic [TAG_W-1:0]  mt [SETS][2];
    logic [DATA_W-1:0] md [SETS][2];
    logic              mp [SETS];

    always #(CLK_PERIOD/2) clk = ~clk;

    wpred_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
        .req_we_i(req_we), .req_wdata_i(req_wdata),
        .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata), .resp_hit_o(resp_hit),
        .resp_slow_o(resp_slow), .resp_miss_o(resp_miss),
        .refill_req_o(refill_req), .refill_addr_o(refill_addr),
        .refill_valid_i(refill_valid), .refill_data_i(refill_data)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] x;
        x = 16'(a) * 16'h9E37;
        return x ^ 16'h1234;
    endfunction

    // Memory model: answers a refill request two cycles after first seeing it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cnt <= '0; refill_valid <= 1'b0; refill_data <= '0;
        end else if (refill_valid) begin
            refill_valid <= 1'b0; mem_cnt <= '0;
        end else if (refill_req) begin
            if (mem_cnt == 2'd1) begin
                refill_valid <= 1'b1; refill_data <= mem_word(refill_addr);
            end else begin
                mem_cnt <= mem_cnt + 2'd1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One access: predict from the model, drive, then compare at negedges.
    task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input string lbl);
        int idx, kind, exp_lat, lat;
        logic [TAG_W-1:0] tg;
        logic p, w;
        logic [DATA_W-1:0] exp_d;
        string rq;
        idx = int'(a[IDX_W-1:0]);
        tg  = a[ADDR_W-1:IDX_W];
        p   = mp[idx];
        if (mv[idx][p] && mt[idx][p] == tg) begin
            kind = 0; w = p; exp_lat = 1;
        end else if (mv[idx][~p] && mt[idx][~p] == tg) begin
            kind = 1; w = ~p; mp[idx] = w; exp_lat = 3;
        end else begin
            kind = 2; exp_lat = 6;
            if (!mv[idx][0]) w = 1'b0;
            else if (!mv[idx][1]) w = 1'b1;
            else w = ~p;
            mv[idx][w] = 1'b1; mt[idx][w] = tg; md[idx][w] = mem_word(a); mp[idx] = w;
        end
        if (we) md[idx][w] = wd;
        exp_d = md[idx][w];
        rq = (lbl != "") ? lbl : (we ? "R9" : (kind == 0 ? "R2" : (kind == 1 ? "R3" : "R5")));

        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready when idle", int'(req_ready), 1);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(posedge clk);
        lat = 0;
        while (1) begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (resp_valid || lat > 40) break;
            chk(req_ready == 1'b0, "R8", "ready while busy", int'(req_ready), 0);
            if (refill_req) chk(refill_addr == a, "R5", "refill address", int'(refill_addr), int'(a));
        end
        chk(resp_valid == 1'b1, rq, "response seen", int'(resp_valid), 1);
        chk({resp_hit, resp_slow, resp_miss} == (3'b100 >> kind), rq, "kind flags",
            int'({resp_hit, resp_slow, resp_miss}), int'(3'b100 >> kind));
        chk(lat == exp_lat, rq, "latency", lat, exp_lat);
        chk(req_ready == 1'b0, "R8", "ready in response cycle", int'(req_ready), 0);
        if (!we) chk(resp_rdata == exp_d, rq, "read data", int'(resp_rdata), int'(exp_d));
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
        return ADDR_W'((tag << IDX_W) | idx);
    endfunction

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mp[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin mv[s][w] = 1'b0; mt[s][w] = '0; md[s][w] = '0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1", "no response after reset", int'(resp_valid), 0);
        chk(refill_req == 1'b0, "R1", "no refill after reset", int'(refill_req), 0);

        // Directed sequence in set 0
        access(1'b0, mk(0, 0), '0, "R7");      // invalid line with reset-like tag must miss
        access(1'b0, mk(0, 0), '0, "R2");      // fast
        access(1'b0, mk(1, 0), '0, "R6");      // miss into invalid way 1
        access(1'b0, mk(0, 0), '0, "R3");      // slow, predictor was way 1
        access(1'b0, mk(0, 0), '0, "R4");      // fast after retrain
        access(1'b1, mk(0, 0), 16'hBEEF, "R9");// write fast hit
        access(1'b0, mk(0, 0), '0, "R9");      // read back write
        access(1'b0, mk(1, 0), '0, "R3");      // slow, predictor now way 1
        access(1'b1, mk(2, 0), 16'hC0DE, "R6");// write miss: full set, victim way 0
        access(1'b0, mk(1, 0), '0, "R6");      // survivor in way 1: slow
        access(1'b0, mk(2, 0), '0, "R9");      // write-allocated word: slow
        access(1'b0, mk(0, 0), '0, "R6");      // evicted tag misses
        access(1'b1, mk(2, 1), 16'h0F0F, "R9");// write miss in another set
        access(1'b0, mk(2, 1), '0, "R9");      // fast read of allocated word

        // Pseudo-random mix: three tags per set contend for two ways
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                access(lf[4] & lf[5], mk(int'(lf[3:2]) % 3, int'(lf[1:0])), lf ^ 16'h5A5A, "");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still ends with the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule